// File: doc/BRIEF.md
# AXI-Lite Width Down-Converter

This block sits between a wide AXI-Lite master and a narrower AXI-Lite slave. The slave port is a power-of-two fraction of the master port's data width. A wide write is broken into a run of narrow writes, one for each slice of the wide data. A wide read is broken into a run of narrow reads, and the returned slices are packed back into one wide data beat. The master sees exactly one response for each wide transaction.

The write path and the read path are independent, so a write and a read may be in progress at the same time. Each path handles one wide transaction at a time. Narrow write slices whose byte strobes are all zero are never put on the slave bus. A wide write with an all-zero strobe is answered at once and never reaches the slave.

Top module: `axil_narrowing_bridge`

## Requirements
- R1: For a wide write at address A, each narrow write goes to the aligned base plus k times the narrow byte width, for slice k. The aligned base is A with its low log2(WIDE_W/8) bits cleared. The narrow write carries data slice k (bits k*NARROW_W upward), and the slices are issued in ascending k.
- R2: The strobe of each narrow write is the matching slice of the wide strobe. A slice whose strobe slice is all zero is skipped entirely, and no narrow write has an empty strobe.
- R3: A wide write whose strobe is all zero produces no narrow traffic and is answered with OKAY (00).
- R4: A wide read issues WIDE_W/NARROW_W narrow reads in ascending slice order, at the same addresses as in R1. Narrow read data k lands in wide read-data slice k.
- R5: The wide response (B or R) is the worst of the narrow responses, ranked DECERR (11) above SLVERR (10) above OKAY (00).
- R6: Once the wide B or R is valid, it stays valid with stable response and data until the master accepts it.
- R7: The wide AW and W beats are accepted in either order, and both are held before the first narrow write starts. No narrow write is driven while the wide B is pending.
- R8: A wide write and a wide read issued concurrently both complete with correct results.
- R9: After reset no valid output is asserted on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_awvalid | input | 1 | Wide write address valid |
| up_awready | output | 1 | Wide write address ready |
| up_awaddr | input | ADDR_W | Wide write byte address |
| up_wvalid | input | 1 | Wide write data valid |
| up_wready | output | 1 | Wide write data ready |
| up_wdata | input | WIDE_W | Wide write data |
| up_wstrb | input | WIDE_W/8 | Wide write byte strobes |
| up_bvalid | output | 1 | Wide write response valid |
| up_bready | input | 1 | Wide write response ready |
| up_bresp | output | 2 | Wide write response code |
| up_arvalid | input | 1 | Wide read address valid |
| up_arready | output | 1 | Wide read address ready |
| up_araddr | input | ADDR_W | Wide read byte address |
| up_rvalid | output | 1 | Wide read data valid |
| up_rready | input | 1 | Wide read data ready |
| up_rdata | output | WIDE_W | Gathered wide read data |
| up_rresp | output | 2 | Wide read response code |
| dn_awvalid | output | 1 | Narrow write address valid |
| dn_awready | input | 1 | Narrow write address ready |
| dn_awaddr | output | ADDR_W | Narrow write byte address |
| dn_wvalid | output | 1 | Narrow write data valid |
| dn_wready | input | 1 | Narrow write data ready |
| dn_wdata | output | NARROW_W | Narrow write data |
| dn_wstrb | output | NARROW_W/8 | Narrow write byte strobes |
| dn_bvalid | input | 1 | Narrow write response valid |
| dn_bready | output | 1 | Narrow write response ready |
| dn_bresp | input | 2 | Narrow write response code |
| dn_arvalid | output | 1 | Narrow read address valid |
| dn_arready | input | 1 | Narrow read address ready |
| dn_araddr | output | ADDR_W | Narrow read byte address |
| dn_rvalid | input | 1 | Narrow read data valid |
| dn_rready | output | 1 | Narrow read data ready |
| dn_rdata | input | NARROW_W | Narrow read data |
| dn_rresp | input | 2 | Narrow read response code |

## Verification
The bench builds the bridge with a 32-bit master side, an 8-bit slave side and 16-bit addresses, which gives four slices per wide beat. With four slices, strobes such as 1010 or 0110 open gaps at the start, in the middle and at the end of a run, so the skip logic is tested in every position and not only at a single boundary. With byte-wide slices, every narrow address inside a wide word is distinct. The slave model can therefore answer SLVERR and DECERR at chosen byte addresses, which makes the response merge across several beats observable.

// File: rtl/axnb_pkg.sv
package axnb_pkg;

   typedef logic [1:0] resp_t;

   localparam resp_t RESP_OKAY   = 2'b00;
   localparam resp_t RESP_SLVERR = 2'b10;
   localparam resp_t RESP_DECERR = 2'b11;

   // error codes outrank success; DECERR outranks SLVERR
   function automatic resp_t resp_worst(input resp_t a, input resp_t b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/axnb_wr_path.sv
module axnb_wr_path
   import axnb_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  up_awvalid,
   output logic                  up_awready,
   input  logic [ADDR_W-1:0]     up_awaddr,
   input  logic                  up_wvalid,
   output logic                  up_wready,
   input  logic [WIDE_W-1:0]     up_wdata,
   input  logic [WIDE_W/8-1:0]   up_wstrb,
   output logic                  up_bvalid,
   input  logic                  up_bready,
   output logic [1:0]            up_bresp,
   output logic                  dn_awvalid,
   input  logic                  dn_awready,
   output logic [ADDR_W-1:0]     dn_awaddr,
   output logic                  dn_wvalid,
   input  logic                  dn_wready,
   output logic [NARROW_W-1:0]   dn_wdata,
   output logic [NARROW_W/8-1:0] dn_wstrb,
   input  logic                  dn_bvalid,
   output logic                  dn_bready,
   input  logic [1:0]            dn_bresp
);

   localparam int RATIO  = WIDE_W / NARROW_W;
   localparam int IDX_W  = $clog2(RATIO);
   localparam int NSTRB  = NARROW_W / 8;
   localparam int WSTRB  = WIDE_W / 8;
   localparam int SB_W   = $clog2(NSTRB);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WSTRB - 1);

   typedef enum logic [1:0] {WR_COLLECT, WR_ISSUE, WR_WAIT, WR_REPLY} wr_state_t;

   wr_state_t             state_q;
   logic                  aw_got_q, w_got_q;
   logic                  aw_sent_q, w_sent_q;
   logic [ADDR_W-1:0]     base_q;
   logic [WIDE_W-1:0]     data_q;
   logic [WSTRB-1:0]      strb_q;
   logic [RATIO-1:0]      pend_q;
   logic [RATIO-1:0]      slice_live;
   logic [RATIO-1:0]      pend_after;
   logic [IDX_W-1:0]      sel;
   resp_t                 acc_q;
   logic                  aw_hs, w_hs, dn_aw_hs, dn_w_hs;

   // one flag per slice: does its strobe slice enable any byte
   for (genvar g = 0; g < RATIO; g++) begin : g_live
      assign slice_live[g] = |up_wstrb[g*NSTRB +: NSTRB];
   end

   // lowest pending slice goes first
   always_comb begin
      sel = '0;
      for (int k = RATIO - 1; k >= 0; k--) begin
         if (pend_q[k]) sel = IDX_W'(k);
      end
   end

   assign pend_after = pend_q & ~(RATIO'(1) << sel);

   assign up_awready = (state_q == WR_COLLECT) && !aw_got_q;
   assign up_wready  = (state_q == WR_COLLECT) && !w_got_q;
   assign aw_hs      = up_awvalid && up_awready;
   assign w_hs       = up_wvalid && up_wready;

   assign dn_awvalid = (state_q == WR_ISSUE) && !aw_sent_q;
   assign dn_wvalid  = (state_q == WR_ISSUE) && !w_sent_q;
   assign dn_aw_hs   = dn_awvalid && dn_awready;
   assign dn_w_hs    = dn_wvalid && dn_wready;
   assign dn_awaddr  = base_q + (ADDR_W'(sel) << SB_W);
   assign dn_wdata   = data_q[int'(sel)*NARROW_W +: NARROW_W];
   assign dn_wstrb   = strb_q[int'(sel)*NSTRB +: NSTRB];
   assign dn_bready  = (state_q == WR_WAIT);

   assign up_bvalid  = (state_q == WR_REPLY);
   assign up_bresp   = acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= WR_COLLECT;
         aw_got_q  <= 1'b0;
         w_got_q   <= 1'b0;
         aw_sent_q <= 1'b0;
         w_sent_q  <= 1'b0;
         base_q    <= '0;
         data_q    <= '0;
         strb_q    <= '0;
         pend_q    <= '0;
         acc_q     <= RESP_OKAY;
      end else begin
         unique case (state_q)
            WR_COLLECT: begin
               if (aw_hs) begin
                  base_q   <= up_awaddr & ALIGN_MASK;
                  aw_got_q <= 1'b1;
               end
               if (w_hs) begin
                  data_q  <= up_wdata;
                  strb_q  <= up_wstrb;
                  pend_q  <= slice_live;
                  w_got_q <= 1'b1;
               end
               if (aw_got_q && w_got_q) begin
                  aw_got_q <= 1'b0;
                  w_got_q  <= 1'b0;
                  acc_q    <= RESP_OKAY;
                  state_q  <= (|pend_q) ? WR_ISSUE : WR_REPLY;
               end
            end
            WR_ISSUE: begin
               if (dn_aw_hs) aw_sent_q <= 1'b1;
               if (dn_w_hs)  w_sent_q  <= 1'b1;
               if ((aw_sent_q || dn_aw_hs) && (w_sent_q || dn_w_hs)) begin
                  aw_sent_q <= 1'b0;
                  w_sent_q  <= 1'b0;
                  state_q   <= WR_WAIT;
               end
            end
            WR_WAIT: begin
               if (dn_bvalid) begin
                  acc_q   <= resp_worst(acc_q, dn_bresp);
                  pend_q  <= pend_after;
                  state_q <= (|pend_after) ? WR_ISSUE : WR_REPLY;
               end
            end
            WR_REPLY: begin
               if (up_bready) state_q <= WR_COLLECT;
            end
            default: state_q <= WR_COLLECT;
         endcase
      end
   end

endmodule

// File: rtl/axnb_rd_path.sv
module axnb_rd_path
   import axnb_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                up_arvalid,
   output logic                up_arready,
   input  logic [ADDR_W-1:0]   up_araddr,
   output logic                up_rvalid,
   input  logic                up_rready,
   output logic [WIDE_W-1:0]   up_rdata,
   output logic [1:0]          up_rresp,
   output logic                dn_arvalid,
   input  logic                dn_arready,
   output logic [ADDR_W-1:0]   dn_araddr,
   input  logic                dn_rvalid,
   output logic                dn_rready,
   input  logic [NARROW_W-1:0] dn_rdata,
   input  logic [1:0]          dn_rresp
);

   localparam int RATIO = WIDE_W / NARROW_W;
   localparam int IDX_W = $clog2(RATIO);
   localparam int NSTRB = NARROW_W / 8;
   localparam int SB_W  = $clog2(NSTRB);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WIDE_W/8 - 1);
   localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(RATIO - 1);

   typedef enum logic [1:0] {RD_IDLE, RD_ISSUE, RD_WAIT, RD_REPLY} rd_state_t;

   rd_state_t         state_q;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WIDE_W-1:0] gather_q;
   resp_t             acc_q;

   assign up_arready = (state_q == RD_IDLE);
   assign dn_arvalid = (state_q == RD_ISSUE);
   assign dn_araddr  = base_q + (ADDR_W'(idx_q) << SB_W);
   assign dn_rready  = (state_q == RD_WAIT);
   assign up_rvalid  = (state_q == RD_REPLY);
   assign up_rdata   = gather_q;
   assign up_rresp   = acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= RD_IDLE;
         base_q   <= '0;
         idx_q    <= '0;
         gather_q <= '0;
         acc_q    <= RESP_OKAY;
      end else begin
         unique case (state_q)
            RD_IDLE: begin
               if (up_arvalid) begin
                  base_q   <= up_araddr & ALIGN_MASK;
                  idx_q    <= '0;
                  gather_q <= '0;
                  acc_q    <= RESP_OKAY;
                  state_q  <= RD_ISSUE;
               end
            end
            RD_ISSUE: begin
               if (dn_arready) state_q <= RD_WAIT;
            end
            RD_WAIT: begin
               if (dn_rvalid) begin
                  gather_q[int'(idx_q)*NARROW_W +: NARROW_W] <= dn_rdata;
                  acc_q <= resp_worst(acc_q, dn_rresp);
                  if (idx_q == LAST_IDX) begin
                     state_q <= RD_REPLY;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= RD_ISSUE;
                  end
               end
            end
            RD_REPLY: begin
               if (up_rready) state_q <= RD_IDLE;
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/axil_narrowing_bridge.sv
module axil_narrowing_bridge #(
   parameter int ADDR_W   = 32,
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  up_awvalid,
   output logic                  up_awready,
   input  logic [ADDR_W-1:0]     up_awaddr,
   input  logic                  up_wvalid,
   output logic                  up_wready,
   input  logic [WIDE_W-1:0]     up_wdata,
   input  logic [WIDE_W/8-1:0]   up_wstrb,
   output logic                  up_bvalid,
   input  logic                  up_bready,
   output logic [1:0]            up_bresp,
   input  logic                  up_arvalid,
   output logic                  up_arready,
   input  logic [ADDR_W-1:0]     up_araddr,
   output logic                  up_rvalid,
   input  logic                  up_rready,
   output logic [WIDE_W-1:0]     up_rdata,
   output logic [1:0]            up_rresp,
   output logic                  dn_awvalid,
   input  logic                  dn_awready,
   output logic [ADDR_W-1:0]     dn_awaddr,
   output logic                  dn_wvalid,
   input  logic                  dn_wready,
   output logic [NARROW_W-1:0]   dn_wdata,
   output logic [NARROW_W/8-1:0] dn_wstrb,
   input  logic                  dn_bvalid,
   output logic                  dn_bready,
   input  logic [1:0]            dn_bresp,
   output logic                  dn_arvalid,
   input  logic                  dn_arready,
   output logic [ADDR_W-1:0]     dn_araddr,
   input  logic                  dn_rvalid,
   output logic                  dn_rready,
   input  logic [NARROW_W-1:0]   dn_rdata,
   input  logic [1:0]            dn_rresp
);

   localparam int RATIO = WIDE_W / NARROW_W;

   // elaboration-time parameter checks
   if (NARROW_W < 8 || (NARROW_W % 8) != 0) begin : g_bad_narrow
      $error("NARROW_W must be a whole number of bytes");
   end
   if ((WIDE_W % NARROW_W) != 0 || RATIO < 2) begin : g_bad_ratio
      $error("WIDE_W must be at least twice NARROW_W and a multiple of it");
   end
   if ((RATIO & (RATIO - 1)) != 0) begin : g_bad_pow2
      $error("WIDE_W / NARROW_W must be a power of two");
   end
   if (ADDR_W <= $clog2(WIDE_W / 8)) begin : g_bad_addr
      $error("ADDR_W too small for the wide data width");
   end

   axnb_wr_path #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_awvalid (up_awvalid),
      .up_awready (up_awready),
      .up_awaddr  (up_awaddr),
      .up_wvalid  (up_wvalid),
      .up_wready  (up_wready),
      .up_wdata   (up_wdata),
      .up_wstrb   (up_wstrb),
      .up_bvalid  (up_bvalid),
      .up_bready  (up_bready),
      .up_bresp   (up_bresp),
      .dn_awvalid (dn_awvalid),
      .dn_awready (dn_awready),
      .dn_awaddr  (dn_awaddr),
      .dn_wvalid  (dn_wvalid),
      .dn_wready  (dn_wready),
      .dn_wdata   (dn_wdata),
      .dn_wstrb   (dn_wstrb),
      .dn_bvalid  (dn_bvalid),
      .dn_bready  (dn_bready),
      .dn_bresp   (dn_bresp)
   );

   axnb_rd_path #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_arvalid (up_arvalid),
      .up_arready (up_arready),
      .up_araddr  (up_araddr),
      .up_rvalid  (up_rvalid),
      .up_rready  (up_rready),
      .up_rdata   (up_rdata),
      .up_rresp   (up_rresp),
      .dn_arvalid (dn_arvalid),
      .dn_arready (dn_arready),
      .dn_araddr  (dn_araddr),
      .dn_rvalid  (dn_rvalid),
      .dn_rready  (dn_rready),
      .dn_rdata   (dn_rdata),
      .dn_rresp   (dn_rresp)
   );

endmodule

// File: rtl/axnb_checker.sv
module axnb_checker #(
   parameter int ADDR_W   = 32,
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  up_bvalid,
   input logic                  up_bready,
   input logic [1:0]            up_bresp,
   input logic                  up_rvalid,
   input logic                  up_rready,
   input logic [WIDE_W-1:0]     up_rdata,
   input logic [1:0]            up_rresp,
   input logic                  dn_awvalid,
   input logic                  dn_awready,
   input logic [ADDR_W-1:0]     dn_awaddr,
   input logic                  dn_wvalid,
   input logic [NARROW_W/8-1:0] dn_wstrb,
   input logic                  dn_arvalid,
   input logic [ADDR_W-1:0]     dn_araddr
);

   localparam logic [ADDR_W-1:0] SLICE_MASK = ADDR_W'(NARROW_W/8 - 1);

   // R2: a narrow write never carries an empty strobe
   p_no_empty_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_wvalid |-> (dn_wstrb != '0));

   // R1: a pending narrow address stays put until taken
   p_aw_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_awvalid && !dn_awready) |=> (dn_awvalid && $stable(dn_awaddr)));

   // R1: narrow write addresses fall on slice boundaries
   p_aw_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dn_awvalid |-> ((dn_awaddr & SLICE_MASK) == '0));

   // R4: narrow read addresses fall on slice boundaries
   p_ar_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dn_arvalid |-> ((dn_araddr & SLICE_MASK) == '0));

   // R6: write response held until accepted
   p_bresp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_bvalid && !up_bready) |=> (up_bvalid && $stable(up_bresp)));

   // R6: read data and response held until accepted
   p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rvalid && !up_rready) |=> (up_rvalid && $stable(up_rdata) && $stable(up_rresp)));

   // R7: no narrow write traffic while the wide response waits
   p_quiet_during_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      up_bvalid |-> (!dn_awvalid && !dn_wvalid));

   // R4: no narrow read while the gathered beat waits
   p_quiet_during_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
      up_rvalid |-> !dn_arvalid);

endmodule

bind axil_narrowing_bridge axnb_checker #(
   .ADDR_W   (ADDR_W),
   .WIDE_W   (WIDE_W),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .up_bvalid  (up_bvalid),
   .up_bready  (up_bready),
   .up_bresp   (up_bresp),
   .up_rvalid  (up_rvalid),
   .up_rready  (up_rready),
   .up_rdata   (up_rdata),
   .up_rresp   (up_rresp),
   .dn_awvalid (dn_awvalid),
   .dn_awready (dn_awready),
   .dn_awaddr  (dn_awaddr),
   .dn_wvalid  (dn_wvalid),
   .dn_wstrb   (dn_wstrb),
   .dn_arvalid (dn_arvalid),
   .dn_araddr  (dn_araddr)
);

// File: tb/axil_narrowing_bridge_bench.sv
module axil_narrowing_bridge_bench;

   localparam int AW = 16;
   localparam int WW = 32;
   localparam int NW = 8;
   localparam int RATIO = WW / NW;
   localparam logic [AW-1:0] ERR_W_SLV = 16'h00F2;
   localparam logic [AW-1:0] ERR_W_DEC = 16'h00F3;
   localparam logic [AW-1:0] ERR_R_SLV = 16'h01C2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            up_awvalid = 0, up_wvalid = 0, up_bready = 0, up_arvalid = 0, up_rready = 0;
   logic [AW-1:0]   up_awaddr = '0, up_araddr = '0;
   logic [WW-1:0]   up_wdata = '0;
   logic [WW/8-1:0] up_wstrb = '0;
   logic            up_awready, up_wready, up_bvalid, up_arready, up_rvalid;
   logic [1:0]      up_bresp, up_rresp;
   logic [WW-1:0]   up_rdata;
   logic            dn_awvalid, dn_wvalid, dn_bready, dn_arvalid, dn_rready;
   logic [AW-1:0]   dn_awaddr, dn_araddr;
   logic [NW-1:0]   dn_wdata;
   logic [NW/8-1:0] dn_wstrb;
   logic            dn_awready, dn_wready, dn_bvalid, dn_arready, dn_rvalid;
   logic [1:0]      dn_bresp, dn_rresp;
   logic [NW-1:0]   dn_rdata;

   axil_narrowing_bridge #(.ADDR_W(AW), .WIDE_W(WW), .NARROW_W(NW)) u_axil_narrowing_bridge (.*);

   int n_tests = 0;
   int n_fail  = 0;

   function automatic logic [7:0] rbyte(input logic [AW-1:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   // ---------------- narrow slave model ----------------
   logic          aw_seen, w_seen, wgate, r_pend;
   logic [AW-1:0] s_awaddr, s_raddr;
   logic [NW-1:0] s_wdata;
   logic [NW/8-1:0] s_wstrb;
   logic [AW-1:0] wl_addr [0:255];
   logic [NW-1:0] wl_data [0:255];
   logic [NW/8-1:0] wl_strb [0:255];
   logic [AW-1:0] rl_addr [0:255];
   int wl_cnt, rl_cnt;

   assign dn_awready = !aw_seen;
   assign dn_wready  = !w_seen && wgate;
   assign dn_arready = !r_pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         aw_seen <= 0; w_seen <= 0; wgate <= 0; r_pend <= 0;
         dn_bvalid <= 0; dn_bresp <= 0; dn_rvalid <= 0; dn_rresp <= 0; dn_rdata <= 0;
         s_awaddr <= 0; s_raddr <= 0; s_wdata <= 0; s_wstrb <= 0;
         wl_cnt <= 0; rl_cnt <= 0;
      end else begin
         wgate <= ~wgate;
         if (dn_awvalid && dn_awready) begin s_awaddr <= dn_awaddr; aw_seen <= 1; end
         if (dn_wvalid && dn_wready) begin s_wdata <= dn_wdata; s_wstrb <= dn_wstrb; w_seen <= 1; end
         if (aw_seen && w_seen && !dn_bvalid) begin
            dn_bvalid <= 1;
            dn_bresp  <= (s_awaddr == ERR_W_DEC) ? 2'b11 : (s_awaddr == ERR_W_SLV) ? 2'b10 : 2'b00;
            wl_addr[wl_cnt] <= s_awaddr;
            wl_data[wl_cnt] <= s_wdata;
            wl_strb[wl_cnt] <= s_wstrb;
            wl_cnt <= wl_cnt + 1;
            aw_seen <= 0; w_seen <= 0;
         end
         if (dn_bvalid && dn_bready) dn_bvalid <= 0;
         if (dn_arvalid && dn_arready) begin
            s_raddr <= dn_araddr; r_pend <= 1;
            rl_addr[rl_cnt] <= dn_araddr; rl_cnt <= rl_cnt + 1;
         end
         if (r_pend && !dn_rvalid) begin
            dn_rvalid <= 1;
            dn_rdata  <= rbyte(s_raddr);
            dn_rresp  <= (s_raddr == ERR_R_SLV) ? 2'b10 : 2'b00;
         end
         if (dn_rvalid && dn_rready) begin dn_rvalid <= 0; r_pend <= 0; end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wide_write(input logic [AW-1:0] a, input logic [WW-1:0] d,
                             input logic [WW/8-1:0] s, input int awd, input int wd,
                             input int bh, output logic [1:0] resp);
      fork
         begin
            repeat (awd) @(negedge clk);
            up_awaddr = a; up_awvalid = 1;
            while (!up_awready) @(negedge clk);
            @(negedge clk); up_awvalid = 0;
         end
         begin
            repeat (wd) @(negedge clk);
            up_wdata = d; up_wstrb = s; up_wvalid = 1;
            while (!up_wready) @(negedge clk);
            @(negedge clk); up_wvalid = 0;
         end
      join
      while (!up_bvalid) @(negedge clk);
      resp = up_bresp;
      for (int h = 0; h < bh; h++) begin
         @(negedge clk);
         chk(up_bvalid && up_bresp == resp, "R6", "bresp hold", {up_bvalid, up_bresp}, {1'b1, resp});
      end
      up_bready = 1;
      @(negedge clk);
      up_bready = 0;
   endtask

   task automatic wide_read(input logic [AW-1:0] a, input int rh,
                            output logic [WW-1:0] data, output logic [1:0] resp);
      up_araddr = a; up_arvalid = 1;
      while (!up_arready) @(negedge clk);
      @(negedge clk); up_arvalid = 0;
      while (!up_rvalid) @(negedge clk);
      data = up_rdata; resp = up_rresp;
      for (int h = 0; h < rh; h++) begin
         @(negedge clk);
         chk(up_rvalid && up_rdata == data && up_rresp == resp, "R6", "rdata hold",
             up_rdata, data);
      end
      up_rready = 1;
      @(negedge clk);
      up_rready = 0;
   endtask

   // check a finished write against the log
   task automatic check_write(input logic [AW-1:0] a, input logic [WW-1:0] d,
                              input logic [WW/8-1:0] s, input int start,
                              input logic [1:0] resp, input string tag);
      int j;
      logic [1:0] er;
      logic [AW-1:0] ea;
      j = 0; er = 2'b00;
      for (int k = 0; k < RATIO; k++) begin
         if (s[k]) begin
            ea = (a & ~AW'(RATIO - 1)) + AW'(k);
            chk(wl_addr[start+j] == ea, "R1", {tag, " addr"}, wl_addr[start+j], ea);
            chk(wl_data[start+j] == d[8*k +: 8], "R1", {tag, " data"}, wl_data[start+j], d[8*k +: 8]);
            chk(wl_strb[start+j] == 1'b1, "R2", {tag, " strb"}, wl_strb[start+j], 1);
            if (ea == ERR_W_DEC) er = 2'b11;
            else if (ea == ERR_W_SLV && er != 2'b11) er = 2'b10;
            j++;
         end
      end
      chk(wl_cnt - start == j, "R2", {tag, " beat count"}, wl_cnt - start, j);
      chk(resp == er, "R5", {tag, " bresp"}, resp, er);
   endtask

   task automatic check_read(input logic [AW-1:0] a, input int start,
                             input logic [WW-1:0] data, input logic [1:0] resp,
                             input string tag);
      logic [WW-1:0] ed;
      logic [1:0] er;
      logic [AW-1:0] ea;
      er = 2'b00;
      for (int k = 0; k < RATIO; k++) begin
         ea = (a & ~AW'(RATIO - 1)) + AW'(k);
         ed[8*k +: 8] = rbyte(ea);
         chk(rl_addr[start+k] == ea, "R4", {tag, " narrow addr"}, rl_addr[start+k], ea);
         if (ea == ERR_R_SLV) er = 2'b10;
      end
      chk(rl_cnt - start == RATIO, "R4", {tag, " beat count"}, rl_cnt - start, RATIO);
      chk(data == ed, "R4", {tag, " gathered data"}, data, ed);
      chk(resp == er, "R5", {tag, " rresp"}, resp, er);
   endtask

   // addr, data, strobe, aw delay, w delay, b hold
   localparam int NV = 7;
   localparam logic [57:0] WVEC [NV] = '{
      {16'h0010, 32'h44332211, 4'b1111, 2'd0, 2'd0, 2'd0},
      {16'h0023, 32'hAABBCCDD, 4'b1010, 2'd0, 2'd2, 2'd1},
      {16'h0030, 32'h00000077, 4'b0001, 2'd2, 2'd0, 2'd0},
      {16'h0042, 32'h99000000, 4'b1000, 2'd1, 2'd1, 2'd2},
      {16'h00F0, 32'h12345678, 4'b0110, 2'd0, 2'd0, 2'd0},
      {16'h00F0, 32'h87654321, 4'b1100, 2'd0, 2'd1, 2'd0},
      {16'h0050, 32'hDEADBEEF, 4'b0000, 2'd0, 2'd0, 2'd1}
   };

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [1:0] resp, rresp;
      logic [WW-1:0] rdata;
      int st, rs;
      repeat (3) @(negedge clk);
      // R9: idle outputs after reset
      chk(!up_bvalid && !up_rvalid && !dn_awvalid && !dn_wvalid && !dn_arvalid, "R9",
          "valids in reset", {up_bvalid, up_rvalid, dn_awvalid, dn_wvalid, dn_arvalid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!up_bvalid && !up_rvalid && !dn_awvalid && !dn_wvalid && !dn_arvalid, "R9",
          "valids after reset", {up_bvalid, up_rvalid, dn_awvalid, dn_wvalid, dn_arvalid}, 0);

      // table walk: R1 R2 R3 R5 R7 (AW/W order varies)
      for (int v = 0; v < NV; v++) begin
         st = wl_cnt;
         wide_write(WVEC[v][57:42], WVEC[v][41:10], WVEC[v][9:6],
                    int'(WVEC[v][5:4]), int'(WVEC[v][3:2]), int'(WVEC[v][1:0]), resp);
         check_write(WVEC[v][57:42], WVEC[v][41:10], WVEC[v][9:6], st, resp, $sformatf("wvec%0d", v));
      end

      // R3: all-zero strobe leaves the slave untouched
      st = wl_cnt;
      wide_write(16'h0070, 32'h11111111, 4'b0000, 1, 0, 0, resp);
      chk(wl_cnt == st, "R3", "zero strobe narrow writes", wl_cnt - st, 0);
      chk(resp == 2'b00, "R3", "zero strobe resp", resp, 0);

      // R4 plain read
      rs = rl_cnt;
      wide_read(16'h0100, 0, rdata, rresp);
      check_read(16'h0100, rs, rdata, rresp, "read plain");

      // R5 + R6: read with an erroring middle slice, response held
      rs = rl_cnt;
      wide_read(16'h01C1, 3, rdata, rresp);
      check_read(16'h01C1, rs, rdata, rresp, "read err");

      // R8: overlapping write and read
      st = wl_cnt; rs = rl_cnt;
      fork
         wide_write(16'h0064, 32'hCAFEF00D, 4'b1111, 0, 1, 1, resp);
         wide_read(16'h0204, 1, rdata, rresp);
      join
      check_write(16'h0064, 32'hCAFEF00D, 4'b1111, st, resp, "R8 concurrent write");
      check_read(16'h0204, rs, rdata, rresp, "R8 concurrent read");

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule